// File: doc/BRIEF.md
# External Memory Port Controller

This block sits between the processor core or DMA requesters and the pins of an off-chip parallel bus. Each request names a space kind (memory, I/O or boot) and an address. The controller picks one of six target spaces from that request: four memory banks, one I/O space and one boot space. It asserts the matching chip select and runs a read or write strobe with the timing programmed for that space. It then reports completion with a one-cycle ready pulse. Memory and boot addresses carry a page number in their top 8 bits, and each page holds 64K words. An I/O address is an 18-bit value built from an 8-bit page input and the low 10 bits of the request address.

Each space has its own 12-bit timing word. The word holds separate read and write wait counts, a clock divide that stretches every wait unit, a write hold extension and a polarity bit for the select and strobe pins. It also holds a bus width bit and a completion mode that additionally waits for an external acknowledge. A 16-bit word sent over an 8-bit bus is moved in two byte cycles. The low byte goes first and the bus idles for one cycle between the bytes.

Top module: `ext_port_ctrl`

## Requirements
- R1: kind 0 (memory) with page = addr[23:16] selects bank 0 for pages 1..63, bank 1 for 64..127, bank 2 for 128..191 and bank 3 for 192..254, on bank_sel_o[3:0]; ext_addr_o carries addr_i unchanged.
- R2: A memory or boot page of 0 or 255, an I/O address below 8192, or kind 3 ends with ready_o and err_o high in the cycle after acceptance. No select or strobe pin moves.
- R3: kind 1 (I/O) forms the address {io_page_i, addr_i[9:0]}, zero-extended, on ext_addr_o. Addresses 8192 and above assert io_sel_o.
- R4: kind 2 (boot) with page 1..254 asserts boot_sel_o and drives addr_i on ext_addr_o.
- R5: Each byte or word cycle holds the strobe for (W+1)*(D+1) cycles. W is the read wait count (cfg[2:0]) or the write wait count (cfg[5:3]), and D is the divide field (cfg[7:6]). The strobe starts in the cycle after acceptance. ready_o pulses for one cycle after the cycle ends, and rd_stb_o and wr_stb_o are never active together.
- R6: With cfg[10]=0 (8-bit bus), a transfer is two strobe cycles. The first uses ext_byte_o=0 and the low byte on lane [7:0]. One idle cycle follows, then a cycle with ext_byte_o=1 and the high byte on lane [7:0]. Read bytes are packed into rdata_o with the first byte in the low half.
- R7: A write whose cfg[8]=1 keeps the select active one extra cycle after the strobe ends, before ready_o. Reads are not extended.
- R8: cfg[9]=1 makes that space's select and its rd/wr strobes active-high. With cfg[9]=0 they are active-low.
- R9: With cfg[11]=1, the strobe stays active past its wait count until ack_i is high. ready_o follows one cycle after the cycle where ack_i is seen high.
- R10: After reset every space holds the word 0x43F: read and write waits 7, divide 0, no hold, active-low, 16-bit bus, no acknowledge wait.
- R11: A request arriving while an access is in progress is ignored. It causes no select, no strobe and no ready pulse.
- R12: A timing word written to a space in the same cycle a request to that space is accepted does not affect that request. The next access uses the new word.
- R13: In reset, ready_o and err_o are low and every select and strobe pin is at its active-low idle level of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled while idle |
| kind_i | input | 2 | Space kind: 0 memory, 1 I/O, 2 boot, 3 reserved |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 24 | Request address, page in bits 23:16 |
| io_page_i | input | 8 | I/O page, upper part of the I/O address |
| wdata_i | input | 16 | Write word |
| ready_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion without a bus cycle |
| rdata_o | output | 16 | Read word, valid with ready_o |
| cfg_we_i | input | 1 | Timing word write enable |
| cfg_sel_i | input | 3 | Space index 0..3 banks, 4 I/O, 5 boot |
| cfg_wdata_i | input | 12 | Timing word |
| ack_i | input | 1 | External acknowledge |
| bank_sel_o | output | 4 | Memory bank selects |
| io_sel_o | output | 1 | I/O space select |
| boot_sel_o | output | 1 | Boot space select |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| ext_addr_o | output | 24 | External address |
| ext_byte_o | output | 1 | High-byte cycle on an 8-bit bus |
| ext_wdata_o | output | 16 | External write data |
| ext_rdata_i | input | 16 | External read data |

## Verification
A timing word update and the acceptance of a request to the same space can land on the same clock edge. The bench provokes this by raising cfg_we_i and req_i on the same cycle for bank 0. It judges the outcome by latency: the first access must take the cycle count of the old read wait, and the access after it must take the count of the new one. A second request arriving while a long access is in progress is also driven. The bench checks that it produces no extra ready pulse and no select on its bank.

// File: rtl/ext_port_pkg.sv
`timescale 1ns/1ps
package ext_port_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int SP_IO      = NUM_BANKS;
  localparam int SP_BOOT    = NUM_BANKS + 1;
  localparam int NUM_SPACES = NUM_BANKS + 2;
  localparam int SPACE_W    = $clog2(NUM_SPACES);
  localparam int WAIT_W     = 3;
  localparam int DIV_W      = 2;
  localparam int PAGE_W     = 8;

  typedef struct packed {
    logic              ack_mode;
    logic              bus16;
    logic              pol;
    logic              hold;
    logic [DIV_W-1:0]  div;
    logic [WAIT_W-1:0] wr_wait;
    logic [WAIT_W-1:0] rd_wait;
  } space_cfg_t;

  localparam int CFG_W = $bits(space_cfg_t);

  localparam space_cfg_t CFG_RESET = '{
    ack_mode: 1'b0, bus16: 1'b1, pol: 1'b0, hold: 1'b0,
    div: '0, wr_wait: '1, rd_wait: '1};

  typedef enum logic [1:0] {
    KIND_MEM  = 2'd0,
    KIND_IO   = 2'd1,
    KIND_BOOT = 2'd2,
    KIND_RSVD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STB, ST_GAP, ST_HOLD, ST_DONE
  } port_state_e;
endpackage

// File: rtl/ext_cfg_regs.sv
`timescale 1ns/1ps
module ext_cfg_regs
  import ext_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SPACE_W-1:0] sel_i,
  input  space_cfg_t         wdata_i,
  output space_cfg_t         cfg_o [NUM_SPACES]
);
  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cfg_o[g] <= CFG_RESET;
      else if (we_i && sel_i == SPACE_W'(g))     cfg_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/ext_space_decode.sv
`timescale 1ns/1ps
module ext_space_decode
  import ext_port_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int IO_PAGE_W   = 8,
  parameter int IO_OFF_W    = 10,
  parameter int IO_INT_SIZE = 8192
) (
  input  kind_e                kind_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [IO_PAGE_W-1:0] io_page_i,
  output logic                 valid_o,
  output logic [SPACE_W-1:0]   space_o,
  output logic [ADDR_W-1:0]    ext_addr_o
);
  localparam int IO_A_W    = IO_PAGE_W + IO_OFF_W;
  localparam int PAGE_LAST = (1 << PAGE_W) - 2;

  logic [PAGE_W-1:0] page;
  logic [IO_A_W-1:0] io_addr;
  logic              page_ok;

  assign page    = addr_i[ADDR_W-1 -: PAGE_W];
  assign io_addr = {io_page_i, addr_i[IO_OFF_W-1:0]};
  assign page_ok = (page != '0) && (page <= PAGE_W'(PAGE_LAST));

  always_comb begin
    valid_o    = 1'b0;
    space_o    = '0;
    ext_addr_o = addr_i;
    unique case (kind_i)
      KIND_MEM: begin
        valid_o = page_ok;
        // fixed 64-page banks: bank index is the top two page bits
        space_o = SPACE_W'(page[PAGE_W-1 -: 2]);
      end
      KIND_IO: begin
        valid_o    = io_addr >= IO_A_W'(IO_INT_SIZE);
        space_o    = SPACE_W'(SP_IO);
        ext_addr_o = ADDR_W'(io_addr);
      end
      KIND_BOOT: begin
        valid_o = page_ok;
        space_o = SPACE_W'(SP_BOOT);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ext_wait_timer.sv
`timescale 1ns/1ps
module ext_wait_timer
  import ext_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              done_o
);
  logic [WAIT_W-1:0] wcnt_q;
  logic [DIV_W-1:0]  dcnt_q, div_q;

  assign done_o = (wcnt_q == '0) && (dcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      dcnt_q <= '0;
      div_q  <= '0;
    end else if (load_i) begin
      wcnt_q <= wait_i;
      dcnt_q <= div_i;
      div_q  <= div_i;
    end else if (!done_o) begin
      if (dcnt_q == '0) begin
        dcnt_q <= div_q;
        wcnt_q <= wcnt_q - 1'b1;
      end else begin
        dcnt_q <= dcnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ext_port_ctrl.sv
`timescale 1ns/1ps
module ext_port_ctrl
  import ext_port_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int IO_PAGE_W   = 8,
  parameter int IO_OFF_W    = 10,
  parameter int IO_INT_SIZE = 8192
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [1:0]           kind_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [IO_PAGE_W-1:0] io_page_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 ready_o,
  output logic                 err_o,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 cfg_we_i,
  input  logic [SPACE_W-1:0]   cfg_sel_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  input  logic                 ack_i,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output logic                 io_sel_o,
  output logic                 boot_sel_o,
  output logic                 rd_stb_o,
  output logic                 wr_stb_o,
  output logic [ADDR_W-1:0]    ext_addr_o,
  output logic                 ext_byte_o,
  output logic [DATA_W-1:0]    ext_wdata_o,
  input  logic [DATA_W-1:0]    ext_rdata_i
);
  localparam int BYTE_W = DATA_W / 2;

  space_cfg_t         cfg_q [NUM_SPACES];
  space_cfg_t         new_cfg, cur_cfg_q;
  port_state_e        state_q;
  logic               dec_valid;
  logic [SPACE_W-1:0] dec_space, cur_space_q;
  logic [ADDR_W-1:0]  dec_addr, ext_addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               cur_we_q, cur_err_q, byte_hi_q, pol_q;
  logic               accept, tmr_load, tmr_done, leave_stb, in_cycle;
  logic [WAIT_W-1:0]  ld_wait;
  logic [DIV_W-1:0]   ld_div;
  logic [NUM_SPACES-1:0] sel_act, sel_pin;
  logic               rd_act, wr_act, cur_ack_mode;

  ext_cfg_regs u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(space_cfg_t'(cfg_wdata_i)), .cfg_o(cfg_q));

  ext_space_decode #(
    .ADDR_W(ADDR_W), .IO_PAGE_W(IO_PAGE_W), .IO_OFF_W(IO_OFF_W),
    .IO_INT_SIZE(IO_INT_SIZE)
  ) u_dec (
    .kind_i(kind_e'(kind_i)), .addr_i(addr_i), .io_page_i(io_page_i),
    .valid_o(dec_valid), .space_o(dec_space), .ext_addr_o(dec_addr));

  assign new_cfg      = cfg_q[dec_space];
  assign accept       = (state_q == ST_IDLE) && req_i;
  assign tmr_load     = accept || (state_q == ST_GAP);
  assign cur_ack_mode = cur_cfg_q.ack_mode;
  assign leave_stb    = tmr_done && (!cur_cfg_q.ack_mode || ack_i);

  always_comb begin
    if (state_q == ST_GAP) begin
      ld_wait = cur_we_q ? cur_cfg_q.wr_wait : cur_cfg_q.rd_wait;
      ld_div  = cur_cfg_q.div;
    end else begin
      ld_wait = we_i ? new_cfg.wr_wait : new_cfg.rd_wait;
      ld_div  = new_cfg.div;
    end
  end

  ext_wait_timer u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .wait_i(ld_wait), .div_i(ld_div), .done_o(tmr_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_cfg_q   <= CFG_RESET;
      cur_space_q <= '0;
      cur_we_q    <= 1'b0;
      cur_err_q   <= 1'b0;
      byte_hi_q   <= 1'b0;
      pol_q       <= 1'b0;
      ext_addr_q  <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          cur_cfg_q   <= new_cfg;
          cur_space_q <= dec_space;
          cur_we_q    <= we_i;
          cur_err_q   <= !dec_valid;
          byte_hi_q   <= 1'b0;
          ext_addr_q  <= dec_addr;
          wdata_q     <= wdata_i;
          if (dec_valid) pol_q <= new_cfg.pol;
          state_q     <= dec_valid ? ST_STB : ST_DONE;
        end
        ST_STB: if (leave_stb) begin
          if (cur_cfg_q.bus16)  rdata_q <= ext_rdata_i;
          else if (!byte_hi_q)  rdata_q[BYTE_W-1:0] <= ext_rdata_i[BYTE_W-1:0];
          else                  rdata_q[DATA_W-1:BYTE_W] <= ext_rdata_i[BYTE_W-1:0];
          if (!cur_cfg_q.bus16 && !byte_hi_q)   state_q <= ST_GAP;
          else if (cur_we_q && cur_cfg_q.hold)  state_q <= ST_HOLD;
          else                                  state_q <= ST_DONE;
        end
        ST_GAP: begin
          byte_hi_q <= 1'b1;
          state_q   <= ST_STB;
        end
        ST_HOLD: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_cycle = (state_q == ST_STB) || (state_q == ST_GAP) || (state_q == ST_HOLD);
  assign sel_act  = in_cycle ? (NUM_SPACES'(1) << cur_space_q) : '0;
  assign rd_act   = (state_q == ST_STB) && !cur_we_q;
  assign wr_act   = (state_q == ST_STB) && cur_we_q;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_pin
    assign sel_pin[g] = sel_act[g] ? cfg_q[g].pol : ~cfg_q[g].pol;
  end

  assign bank_sel_o  = sel_pin[NUM_BANKS-1:0];
  assign io_sel_o    = sel_pin[SP_IO];
  assign boot_sel_o  = sel_pin[SP_BOOT];
  assign rd_stb_o    = rd_act ? pol_q : ~pol_q;
  assign wr_stb_o    = wr_act ? pol_q : ~pol_q;
  assign ext_addr_o  = ext_addr_q;
  assign ext_byte_o  = byte_hi_q;
  assign ext_wdata_o = cur_cfg_q.bus16 ? wdata_q :
                       {{(DATA_W-BYTE_W){1'b0}},
                        byte_hi_q ? wdata_q[DATA_W-1:BYTE_W] : wdata_q[BYTE_W-1:0]};
  assign ready_o     = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_DONE) && cur_err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/ext_port_ctrl_chk.sv
`timescale 1ns/1ps
module ext_port_ctrl_chk
  import ext_port_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SPACES-1:0] sel_act_i,
  input logic                  rd_act_i,
  input logic                  wr_act_i,
  input logic                  ready_i,
  input logic                  err_i,
  input logic                  ack_mode_i,
  input logic                  ack_i
);
  a_r1_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_act_i));

  a_r2_err_without_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $past(sel_act_i) == '0);

  a_r5_strobe_inside_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_i || wr_act_i) |-> sel_act_i != '0);

  a_r5_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_act_i && wr_act_i));

  a_r5_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ready_i);

  a_r7_ready_after_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !err_i) |-> $past(sel_act_i) != '0);

  a_r9_wait_for_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_act_i || wr_act_i) && ack_mode_i && !ack_i) |=> (rd_act_i || wr_act_i));
endmodule

bind ext_port_ctrl ext_port_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_act_i(sel_act), .rd_act_i(rd_act),
  .wr_act_i(wr_act), .ready_i(ready_o), .err_i(err_o),
  .ack_mode_i(cur_ack_mode), .ack_i(ack_i));

// File: tb/ext_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_port_ctrl_tb_top;
  import ext_port_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, cfg_we = 1'b0, ack = 1'b1;
  logic [1:0] kind = '0;
  logic [23:0] addr = '0;
  logic [7:0] io_page = '0;
  logic [15:0] wdata = '0;
  logic [2:0] cfg_sel = '0;
  logic [11:0] cfg_wdata = '0;
  logic ready, err, rd_stb, wr_stb, io_sel, boot_sel, ext_byte;
  logic [3:0] bank_sel;
  logic [15:0] rdata, ext_wdata, ext_rdata;
  logic [23:0] ext_addr;

  always #5 clk = ~clk;

  function automatic logic [7:0] hi_of(input logic [23:0] a);
    return a[15:8] ^ 8'h5A;
  endfunction
  assign ext_rdata = ext_byte ? {8'h00, hi_of(ext_addr)} : {hi_of(ext_addr), ext_addr[7:0]};

  ext_port_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .we_i(we),
    .addr_i(addr), .io_page_i(io_page), .wdata_i(wdata), .ready_o(ready),
    .err_o(err), .rdata_o(rdata), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .ack_i(ack), .bank_sel_o(bank_sel),
    .io_sel_o(io_sel), .boot_sel_o(boot_sel), .rd_stb_o(rd_stb),
    .wr_stb_o(wr_stb), .ext_addr_o(ext_addr), .ext_byte_o(ext_byte),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata));

  int nchk = 0, nerr = 0;
  space_cfg_t shadow [6];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // results of the last access
  int lat, rd_on, wr_on, chg;
  logic [5:0] mask;
  logic [23:0] a_seen;
  logic [15:0] w_word, rd_word;
  logic [7:0] w_lo, w_hi;
  logic err_seen;

  task automatic run_access(input logic [1:0] k, input logic [23:0] a, input logic [7:0] pg,
                            input logic w, input logic [15:0] wd, input logic p,
                            input logic cw, input logic [11:0] cv);
    logic pre_rd, pre_wr;
    logic [5:0] pins;
    @(negedge clk);
    kind = k; addr = a; io_page = pg; we = w; wdata = wd; req = 1'b1;
    cfg_we = cw; cfg_sel = 3'd0; cfg_wdata = cv;
    pre_rd = rd_stb; pre_wr = wr_stb;
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    lat = 1; mask = '0; rd_on = 0; wr_on = 0; chg = 0;
    a_seen = '0; w_word = '0; w_lo = '0; w_hi = '0;
    while (!ready && lat < 200) begin
      pins = {boot_sel, io_sel, bank_sel};
      for (int i = 0; i < 6; i++) if (pins[i] == shadow[i].pol) mask[i] = 1'b1;
      if (rd_stb != pre_rd || wr_stb != pre_wr) chg++;
      if (rd_stb == p) begin rd_on++; a_seen = ext_addr; end
      if (wr_stb == p) begin
        wr_on++; a_seen = ext_addr;
        if (ext_byte) w_hi = ext_wdata[7:0];
        else begin w_lo = ext_wdata[7:0]; w_word = ext_wdata; end
      end
      @(negedge clk);
      lat++;
    end
    rd_word = rdata; err_seen = err;
  endtask

  task automatic set_cfg(input int sp, input logic [11:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sp); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[sp] = space_cfg_t'(v);
  endtask

  function automatic int strobe_len(input int sp, input logic w);
    int wt;
    wt = w ? int'(shadow[sp].wr_wait) : int'(shadow[sp].rd_wait);
    return (wt + 1) * (int'(shadow[sp].div) + 1);
  endfunction

  function automatic int exp_lat(input int sp, input logic w);
    int b;
    b = shadow[sp].bus16 ? 1 : 2;
    return strobe_len(sp, w) * b + (b - 1) + ((w && shadow[sp].hold) ? 1 : 0) + 1;
  endfunction

  typedef struct packed {
    logic [1:0]  kind;
    logic [23:0] addr;
    logic [7:0]  pg;
    logic        we;
    logic [15:0] wd;
    logic [2:0]  sp;   // 7: error expected
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 24'h010010, 8'h00, 1'b0, 16'h0000, 3'd0},
    '{2'd0, 24'h3F1234, 8'h00, 1'b1, 16'hBEEF, 3'd0},
    '{2'd0, 24'h4000AA, 8'h00, 1'b0, 16'h0000, 3'd1},
    '{2'd0, 24'h7F0F0F, 8'h00, 1'b1, 16'h1234, 3'd1},
    '{2'd0, 24'h800001, 8'h00, 1'b0, 16'h0000, 3'd2},
    '{2'd0, 24'hBFFFFF, 8'h00, 1'b1, 16'hA55A, 3'd2},
    '{2'd0, 24'hC00002, 8'h00, 1'b0, 16'h0000, 3'd3},
    '{2'd0, 24'hFE0000, 8'h00, 1'b0, 16'h0000, 3'd3},
    '{2'd0, 24'h001234, 8'h00, 1'b0, 16'h0000, 3'd7},
    '{2'd0, 24'hFF0000, 8'h00, 1'b1, 16'h1111, 3'd7},
    '{2'd1, 24'h000005, 8'h08, 1'b0, 16'h0000, 3'd4},
    '{2'd1, 24'h0003FF, 8'hFF, 1'b1, 16'hC3A7, 3'd4},
    '{2'd1, 24'h0003FF, 8'h07, 1'b0, 16'h0000, 3'd7},
    '{2'd2, 24'h010000, 8'h00, 1'b0, 16'h0000, 3'd5},
    '{2'd2, 24'hFE0100, 8'h00, 1'b1, 16'h7E81, 3'd5},
    '{2'd2, 24'h000100, 8'h00, 1'b0, 16'h0000, 3'd7},
    '{2'd3, 24'h010000, 8'h00, 1'b0, 16'h0000, 3'd7}
  };

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) shadow[i] = space_cfg_t'(12'h43F); // R10 reset word
    repeat (3) @(negedge clk);
    // R13 reset state
    check(ready == 1'b0 && err == 1'b0, "R13 ready/err in reset", {ready, err}, 0);
    check({boot_sel, io_sel, bank_sel} == 6'h3F, "R13 selects idle high",
          {boot_sel, io_sel, bank_sel}, 6'h3F);
    check(rd_stb && wr_stb, "R13 strobes idle high", {rd_stb, wr_stb}, 3);
    rst_n = 1'b1;

    set_cfg(0, 12'h40A);
    set_cfg(1, 12'h300);
    set_cfg(2, 12'h541);
    set_cfg(4, 12'h001);
    set_cfg(5, 12'h690);

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      logic [23:0] ea;
      int sp, s, b;
      string tag;
      e = VECS[v];
      sp = int'(e.sp);
      if (e.sp == 3'd7) begin
        run_access(e.kind, e.addr, e.pg, e.we, e.wd, 1'b0, 1'b0, 12'h0);
        check(err_seen == 1'b1, "R2 error flag", err_seen, 1);
        check(mask == '0, "R2 no select", mask, 0);
        check(chg == 0, "R2 strobes untouched", chg, 0);
        check(lat == 1, "R2 error latency", lat, 1);
      end else begin
        run_access(e.kind, e.addr, e.pg, e.we, e.wd, shadow[sp].pol, 1'b0, 12'h0);
        ea = (e.kind == 2'd1) ? {6'b0, e.pg, e.addr[9:0]} : e.addr;
        tag = (e.kind == 2'd0) ? "R1" : (e.kind == 2'd1) ? "R3" : "R4";
        s = strobe_len(sp, e.we);
        b = shadow[sp].bus16 ? 1 : 2;
        check(err_seen == 1'b0, {tag, " no error"}, err_seen, 0);
        check(mask == 6'(1 << sp), {tag, " select"}, mask, 1 << sp);
        check(a_seen == ea, {tag, " external address"}, a_seen, ea);
        if (shadow[sp].pol)
          check(mask == 6'(1 << sp), "R8 active-high select", mask, 1 << sp);
        check(lat == exp_lat(sp, e.we), (sp == 3) ? "R10 reset timing" :
              (e.we && shadow[sp].hold) ? "R7 hold latency" : "R5 latency",
              lat, exp_lat(sp, e.we));
        check((e.we ? wr_on : rd_on) == s * b, "R5 strobe cycles",
              e.we ? wr_on : rd_on, s * b);
        check((e.we ? rd_on : wr_on) == 0, "R5 other strobe idle",
              e.we ? rd_on : wr_on, 0);
        if (!e.we)
          check(rd_word == {hi_of(ea), ea[7:0]}, b == 2 ? "R6 byte packing" : "R5 read data",
                rd_word, {hi_of(ea), ea[7:0]});
        else if (b == 2)
          check({w_hi, w_lo} == e.wd, "R6 byte write order", {w_hi, w_lo}, e.wd);
        else
          check(w_word == e.wd, "R5 write data", w_word, e.wd);
      end
    end

    // R9 completion waits for acknowledge
    begin
      int rdy = 0, act = 0;
      set_cfg(0, 12'hC0A);
      @(negedge clk);
      ack = 1'b0; kind = 2'd0; addr = 24'h010020; we = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (ready) rdy++;
        if (rd_stb == 1'b0) act++;
      end
      check(rdy == 0 && act == 8, "R9 strobe held without ack", act, 8);
      ack = 1'b1;
      @(negedge clk);
      check(ready == 1'b1, "R9 ready after ack", ready, 1);
      set_cfg(0, 12'h40A);
    end

    // R11 request during a busy access is ignored
    begin
      int rdy = 0, b0 = 0;
      @(negedge clk);
      kind = 2'd0; addr = 24'hC00002; we = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (2) @(negedge clk);
      addr = 24'h010000; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (20) begin
        if (ready) rdy++;
        if (bank_sel[0] == 1'b0) b0++;
        @(negedge clk);
      end
      check(rdy == 1, "R11 single ready pulse", rdy, 1);
      check(b0 == 0, "R11 ignored request drove no select", b0, 0);
    end

    // R12 timing word written in the accepting cycle
    begin
      int e_old, e_new;
      e_old = exp_lat(0, 1'b0);
      run_access(2'd0, 24'h020000, 8'h00, 1'b0, 16'h0, 1'b0, 1'b1, 12'h40D);
      check(lat == e_old, "R12 access uses old word", lat, e_old);
      shadow[0] = space_cfg_t'(12'h40D);
      e_new = exp_lat(0, 1'b0);
      run_access(2'd0, 24'h020000, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 12'h0);
      check(lat == e_new, "R12 next access uses new word", lat, e_new);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule